// File: doc/BRIEF.md
# I2C Master Stop Sequencer

This block produces the Stop condition at the end of an I2C master transfer and watches the bus for another master while it does so. A one-cycle request starts the sequence. The block first pulls SDA low while it holds SCL low. It lets SCL float once SDA reads low, and then times one baud-rate high period. That period starts only when SCL actually reads high, so a slave that stretches the clock simply lengthens the sequence. After the period the block lets SDA float high. It waits a further period and then checks that SDA really rose.

Two things count as a bus collision. One is SCL reading low while the block is timing the SCL high period. The other is SDA still reading low at the final check. A collision releases both lines at once and raises a sticky collision flag. A clean finish raises a sticky completion flag instead. The two output pins are pull-low enables for open-drain pads. The bus levels come back through a synchronizer inside the block.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, `sda_pull`, `scl_pull`, `stop_busy`, `done_flag` and `bcol_flag` are all 0.
- R2: A `stop_req` pulse while idle makes `stop_busy` 1 on the next cycle, with both `sda_pull` and `scl_pull` at 1.
- R3: `scl_pull` stays 1 until the synchronized SDA reads low. With SDA low immediately, `scl_pull` is 1 for 3 cycles of the busy sequence. Each cycle that SDA is kept reading high adds one cycle.
- R4: The high period is P = reload, except that reload 0 gives P = 1. `sda_pull` falls P+3 cycles after `scl_pull` falls when SCL rises at once. Each cycle that SCL is held low by the bus (stretching) adds one cycle.
- R5: Once SDA is released, the block waits Q = max(P, 3) cycles and then samples SDA. If SDA reads high, `stop_busy` falls, `done_flag` becomes 1 and both pulls are 0.
- R6: If SDA reads low at the end of the release wait, `bcol_flag` becomes 1 and `done_flag` stays 0.
- R7: If SCL reads low after it has been seen high but before SDA is released, the block reports a collision through `bcol_flag`.
- R8: On any collision, `sda_pull`, `scl_pull` and `stop_busy` are all 0 on the following cycle, and `done_flag` is not set.
- R9: Both flags stay set until `flag_clr` is pulsed. The pulse clears both; a flag set in the same cycle wins.
- R10: A `stop_req` while `stop_busy` is 1 has no effect. The sequence timing is unchanged, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle request to start a Stop |
| reload | input | 7 | Baud-rate reload value |
| sda_in | input | 1 | SDA pad level (asynchronous) |
| scl_in | input | 1 | SCL pad level (asynchronous) |
| flag_clr | input | 1 | Clears both sticky flags |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| stop_busy | output | 1 | Sequence in progress; clears itself at the end |
| done_flag | output | 1 | Sticky clean-Stop flag |
| bcol_flag | output | 1 | Sticky bus-collision flag |

## Verification
Assertions check the ordering rules on every cycle:
- SCL is released only after SDA was seen low.
- SDA is released only on a timer expiry.
- Every end of the sequence carries exactly one outcome.
- A collision leaves both lines free.
- The flags hold until they are cleared.

The exact cycle counts of each phase can only be shown by the bench's scenarios. The same holds for clock stretching extending the high phase, and for the floor on the release wait. The bench also injects the two kinds of collision at chosen moments and sends a request in the middle of a sequence.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  localparam int RELOAD_W  = 7;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LOW,
    ST_WAIT_SCL,
    ST_HOLD,
    ST_RELEASE
  } stop_state_e;

  // SCL high time in cycles: a reload of zero still gives one cycle
  function automatic logic [RELOAD_W-1:0] high_period(input logic [RELOAD_W-1:0] r);
    return (r == '0) ? RELOAD_W'(1) : r;
  endfunction

  // release wait: never shorter than the synchronizer delay plus one
  function automatic logic [RELOAD_W-1:0] check_period(input logic [RELOAD_W-1:0] r,
                                                        input int floor_cyc);
    logic [RELOAD_W-1:0] p;
    p = high_period(r);
    return (int'(p) < floor_cyc) ? RELOAD_W'(floor_cyc) : p;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[i] <= '1;
        else        stage[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[i] <= '1;
        else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_brg_timer.sv
module i2c_brg_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (en && cnt > W'(1))    cnt <= cnt - W'(1);

  assign expire = en && (cnt == W'(1));

  // R4: a running timer has always been loaded with a nonzero period
  p_run_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt != '0);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int RW    = RELOAD_W,
  parameter int SYNCN = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic [RW-1:0] reload,
  input  logic          sda_in,
  input  logic          scl_in,
  input  logic          flag_clr,
  output logic          sda_pull,
  output logic          scl_pull,
  output logic          stop_busy,
  output logic          done_flag,
  output logic          bcol_flag
);
  localparam int FLOOR = SYNCN + 1;

  stop_state_e st, nxt;
  logic        sda_s, scl_s;
  logic [1:0]  lines_s;
  logic        tmr_load, tmr_en, tmr_expire;
  logic [RW-1:0] tmr_val;
  logic        ev_done, ev_bcol;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNCN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(lines_s));
  assign sda_s = lines_s[1];
  assign scl_s = lines_s[0];

  i2c_brg_timer #(.W(RW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .expire(tmr_expire));

  // outcome events, named for the assertions
  assign ev_bcol = ((st == ST_HOLD) && !scl_s) ||
                   ((st == ST_RELEASE) && tmr_expire && !sda_s);
  assign ev_done = (st == ST_RELEASE) && tmr_expire && sda_s;

  assign tmr_en   = (st == ST_HOLD) || (st == ST_RELEASE);
  assign tmr_load = ((st == ST_WAIT_SCL) && scl_s) ||
                    ((st == ST_HOLD) && scl_s && tmr_expire);
  assign tmr_val  = (st == ST_WAIT_SCL) ? high_period(reload)
                                        : check_period(reload, FLOOR);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:     if (stop_req) nxt = ST_SDA_LOW;
      ST_SDA_LOW:  if (!sda_s)   nxt = ST_WAIT_SCL;
      ST_WAIT_SCL: if (scl_s)    nxt = ST_HOLD;
      ST_HOLD: begin
        if (!scl_s)          nxt = ST_IDLE;
        else if (tmr_expire) nxt = ST_RELEASE;
      end
      ST_RELEASE:  if (tmr_expire) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_flag <= 1'b0;
      bcol_flag <= 1'b0;
    end else begin
      done_flag <= ev_done | (done_flag & ~flag_clr);
      bcol_flag <= ev_bcol | (bcol_flag & ~flag_clr);
    end

  assign sda_pull  = (st == ST_SDA_LOW) || (st == ST_WAIT_SCL) || (st == ST_HOLD);
  assign scl_pull  = (st == ST_SDA_LOW);
  assign stop_busy = (st != ST_IDLE);

  // R2: a sequence only begins on a request
  p_start_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_busy) |-> $past(stop_req));
  // R3: SCL is let go only after SDA was seen low
  p_scl_after_sda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> ($past(!sda_s) && sda_pull));
  // R4: SDA is let go during a sequence only on timer expiry
  p_sda_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && stop_busy) |-> $past(tmr_expire));
  // R5: every end of a sequence carries an outcome
  p_end_has_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_busy) |-> $past(ev_done || ev_bcol));
  // R8: never both outcomes, and a collision frees both lines
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_done && ev_bcol));
  p_bcol_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_bcol) |-> (!sda_pull && !scl_pull && !stop_busy));
  // R9: flags hold unless cleared
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_flag) && !$past(flag_clr)) |-> done_flag);
  p_bcol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bcol_flag) && !$past(flag_clr)) |-> bcol_flag);
endmodule

// File: tb/test_i2c_stop_seq.sv
module test_i2c_stop_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic [6:0] reload = '0;
  logic       flag_clr = 1'b0;
  logic       ext_sda = 1'b0, ext_scl = 1'b0, force_hi = 1'b0;
  logic       sda_pull, scl_pull, stop_busy, done_flag, bcol_flag;
  logic       sda_line, scl_line;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // open-drain bus: any puller wins; force_hi models SDA reading high
  assign sda_line = force_hi | ~(sda_pull | ext_sda);
  assign scl_line = ~(scl_pull | ext_scl);

  i2c_stop_seq i_i2c_stop_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .sda_in(sda_line), .scl_in(scl_line), .flag_clr(flag_clr),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .stop_busy(stop_busy),
    .done_flag(done_flag), .bcol_flag(bcol_flag));

  typedef struct {
    int kind;   // 0 clean, 1 SCL collision, 2 SDA collision
    int p;
    int q;
    int s;
    int f;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: window counts per sequence, compared on sequence end
  int  w0, w1, w2;
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stop_busy) begin
        if (!prev_busy) begin w0 = 0; w1 = 0; w2 = 0; end
        if (scl_pull) w0++;
        if (!scl_pull && sda_pull) w1++;
        if (!sda_pull) w2++;
      end
      if (prev_busy && !stop_busy) begin
        item_t it;
        if (sb_q.size() == 0) begin
          chk("R10 unexpected sequence end", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk("R3 SCL held until SDA low", w0, it.f + 3);
          chk("R8 pulls released at end", int'(sda_pull | scl_pull), 0);
          if (it.kind == 0) begin
            chk("R4 SCL high period", w1, it.p + 3 + it.s);
            chk("R5 release wait", w2, it.q);
            chk("R5 done flag", int'(done_flag), 1);
            chk("R5 no collision", int'(bcol_flag), 0);
          end else begin
            chk(it.kind == 1 ? "R7 collision flag" : "R6 collision flag", int'(bcol_flag), 1);
            chk("R8 no done on collision", int'(done_flag), 0);
          end
        end
      end
      prev_busy = stop_busy;
    end
  end

  task automatic run_stop(input int rl, input int s, input int f, input int kind, input bit midreq);
    item_t it;
    it.kind = kind;
    it.p = (rl == 0) ? 1 : rl;
    it.q = (it.p < 3) ? 3 : it.p;
    it.s = s;
    it.f = f;
    @(negedge clk);
    reload = 7'(rl);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    sb_q.push_back(it);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R2 start pulls and busy", int'({sda_pull, scl_pull, stop_busy}), 7);
    if (f > 0) begin
      force_hi = 1'b1;
      repeat (f) @(negedge clk);
      force_hi = 1'b0;
    end
    while (scl_pull) @(negedge clk);
    if (s > 0) begin
      ext_scl = 1'b1;
      repeat (s) @(negedge clk);
      ext_scl = 1'b0;
    end
    if (kind == 1) begin
      repeat (8) @(negedge clk);
      ext_scl = 1'b1;
    end
    if (midreq) begin
      repeat (4) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
    end
    if (kind == 2) begin
      while (sda_pull && stop_busy) @(negedge clk);
      ext_sda = 1'b1;
    end
    while (stop_busy) @(negedge clk);
    ext_scl = 1'b0;
    ext_sda = 1'b0;
    repeat (3) @(negedge clk);
    if (midreq) chk("R10 no restart after ignored request", int'(stop_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({sda_pull, scl_pull, stop_busy, done_flag, bcol_flag}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'({sda_pull, scl_pull, stop_busy, done_flag, bcol_flag}), 0);

    run_stop(0, 0, 0, 0, 1'b0);    // R4 reload zero, R5 floor
    run_stop(1, 0, 0, 0, 1'b0);
    run_stop(5, 0, 0, 0, 1'b0);
    run_stop(127, 7, 4, 0, 1'b1);  // stretching, slow SDA, R10 mid request

    repeat (10) @(negedge clk);
    chk("R9 done flag sticky", int'(done_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 clear drops done", int'(done_flag), 0);

    run_stop(20, 0, 2, 1, 1'b0);   // R7 SCL pulled low during high phase
    run_stop(9, 0, 0, 2, 1'b0);    // R6 SDA held low at check
    repeat (10) @(negedge clk);
    chk("R9 collision flag sticky", int'(bcol_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 clear drops collision", int'(bcol_flag), 0);

    run_stop(3, 2, 0, 0, 1'b0);    // clean after collisions
    repeat (5) @(negedge clk);
    chk("R5 scoreboard drained", sb_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule